// File: doc/BRIEF.md
# Speculative Load Address Check Table

This block keeps track of loads that software has moved ahead of stores that might alias them. When an advanced load issues, it records its destination register and its address in a small associative table. Every store that follows is compared with all live entries at once, and any entry whose address matches the store is dropped. When the program reaches the point where the hoisted value is consumed, a check operation looks up the destination register. If a live entry is still present, the speculation held and execution continues. If the entry was killed by a store, or was never there or was evicted, the block raises a recovery request so that software branches to its fixup code.

Each table slot is a two-state machine with the states `ENT_EMPTY` and `ENT_LIVE`. It has five named transitions. `T_INSTALL` goes from empty to live on an insert. `T_REFILL` stays live when a new insert overwrites the slot. `T_SNOOP_KILL` goes from live to empty when a store matches. `T_CHECK_DROP` goes from live to empty on a check with the clear flag set. `T_FLUSH` takes any state to empty.

The allocator decides each insert in one of four modes:
- `ALLOC_NONE`: there is no insert.
- `ALLOC_REFRESH`: the same register is already live.
- `ALLOC_FILL`: the insert goes to the lowest empty slot.
- `ALLOC_EVICT`: the table is full and a round-robin victim is replaced.

Top module: `spec_ld_table`

## Requirements
- R1: After reset every slot is empty, so a check of any register raises `chk_recover_o` and leaves `chk_ok_o` low.
- R2: After an insert of register r at address a, a later check of r raises `chk_ok_o` as long as no store, clear, eviction or flush has removed it.
- R3: A store kills every live entry whose address equals the store address in bits [31:3]. Bits [2:0] are ignored. A store that differs in any bit from 3 upward leaves the entry live. The killed entry is gone from the next cycle on.
- R4: Check outputs are combinational in the cycle of the check. `chk_ok_o` = `chk_valid_i` and a live entry holds `chk_reg_i`. `chk_recover_o` = `chk_valid_i` and no live entry holds it. Both outputs are low when no check is requested. The lookup sees the table as it stood at the start of the cycle, so an insert or a store in the same cycle is not yet visible to it.
- R5: A check with `chk_clear_i` low leaves the entry live. A check with `chk_clear_i` high removes the entry for that register from the next cycle on.
- R6: An insert for a register that already has a live entry overwrites that entry with the new address. At most one live entry exists per register.
- R7: An insert for a new register takes the lowest-index empty slot. If all slots are live, it replaces the slot named by a round-robin pointer. The pointer starts at slot 0 and advances by one, wrapping after the last slot, only on such replacements.
- R8: An insert takes effect after a same-cycle store or check-clear. Even when the store address or the cleared register matches the insert, the new entry is live in the next cycle.
- R9: A flush empties every slot and returns the round-robin pointer to slot 0 in one cycle. It wins over a same-cycle insert.
- R10: With `ins_valid_i` low, or with `st_valid_i` low, the address and register inputs of that port have no effect on the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Empty the whole table |
| ins_valid_i | input | 1 | Advanced-load insert request |
| ins_reg_i | input | 7 | Destination register of the advanced load |
| ins_addr_i | input | 32 | Address of the advanced load |
| st_valid_i | input | 1 | Store snoop request |
| st_addr_i | input | 32 | Store address |
| chk_valid_i | input | 1 | Check request |
| chk_reg_i | input | 7 | Register being checked |
| chk_clear_i | input | 1 | Remove the entry as part of the check |
| chk_ok_o | output | 1 | Speculation held |
| chk_recover_o | output | 1 | Entry killed or absent; branch to fixup |

## Verification
The bench targets the 8-byte match boundary. A store that differs only in the low three bits must still kill the entry, and a store one granule away must not. A comparator with the wrong width would either miss real aliases or kill entries for no reason. It checks operations that share a cycle: insert with store, insert with clear, check with insert or store, and flush with insert. A design that got the order wrong would lose fresh entries or report results one cycle early. It fills the table, evicts, frees a middle slot and evicts again. This catches a pointer that moves on fills or survives a flush, because that would evict the wrong register. Random traffic on a small register and address set is then compared cycle by cycle against a behavioural model.

// File: rtl/spec_ld_pkg.sv
package spec_ld_pkg;

    typedef enum logic {
        ENT_EMPTY = 1'b0,
        ENT_LIVE  = 1'b1
    } ent_state_e;

    typedef enum logic [1:0] {
        ALLOC_NONE    = 2'd0,
        ALLOC_REFRESH = 2'd1,
        ALLOC_FILL    = 2'd2,
        ALLOC_EVICT   = 2'd3
    } alloc_mode_e;

endpackage

// File: rtl/spec_ld_entry.sv
module spec_ld_entry
    import spec_ld_pkg::*;
#(
    parameter int REG_W    = 7,
    parameter int ADDR_W   = 32,
    parameter int IGN_BITS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic              load_i,
    input  logic [REG_W-1:0]  ins_reg_i,
    input  logic [ADDR_W-1:0] ins_addr_i,
    input  logic              st_valid_i,
    input  logic [ADDR_W-1:0] st_addr_i,
    input  logic              chk_valid_i,
    input  logic [REG_W-1:0]  chk_reg_i,
    input  logic              chk_clear_i,
    output logic              live_o,
    output logic              ins_hit_o,
    output logic              chk_hit_o
);

    localparam int TAG_LO = IGN_BITS;

    ent_state_e        state_q, state_d;
    logic [REG_W-1:0]  reg_q;
    logic [ADDR_W-1:0] addr_q;
    logic              st_hit;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ENT_EMPTY;
        else        state_q <= state_d;
    end

    // payload captured on install or refill
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_q  <= '0;
            addr_q <= '0;
        end else if (load_i && !flush_i) begin
            reg_q  <= ins_reg_i;
            addr_q <= ins_addr_i;
        end
    end

    // match outputs
    always_comb begin
        live_o    = (state_q == ENT_LIVE);
        st_hit    = live_o && st_valid_i &&
                    (st_addr_i[ADDR_W-1:TAG_LO] == addr_q[ADDR_W-1:TAG_LO]);
        chk_hit_o = live_o && chk_valid_i && (chk_reg_i == reg_q);
        ins_hit_o = live_o && (ins_reg_i == reg_q);
    end

    // transitions: T_INSTALL, T_REFILL, T_SNOOP_KILL, T_CHECK_DROP, T_FLUSH
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ENT_EMPTY: begin
                if (load_i && !flush_i) state_d = ENT_LIVE;
            end
            ENT_LIVE: begin
                if (flush_i)                              state_d = ENT_EMPTY;
                else if (load_i)                          state_d = ENT_LIVE;
                else if (st_hit || (chk_hit_o && chk_clear_i)) state_d = ENT_EMPTY;
            end
            default: state_d = ENT_EMPTY;
        endcase
    end

    AST_STORE_KILL: assert property (@(posedge clk) disable iff (!rst_n)
        (st_hit && !load_i && !flush_i) |=> (state_q == ENT_EMPTY)); // R3

    AST_CLEAR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_hit_o && chk_clear_i && !load_i && !flush_i) |=> (state_q == ENT_EMPTY)); // R5

    AST_INSERT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !flush_i) |=> (state_q == ENT_LIVE && reg_q == $past(ins_reg_i))); // R8

    AST_ENTRY_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (state_q == ENT_EMPTY)); // R9

endmodule

// File: rtl/spec_ld_alloc.sv
module spec_ld_alloc
    import spec_ld_pkg::*;
#(
    parameter int N_ENTRIES = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 flush_i,
    input  logic                 ins_valid_i,
    input  logic [N_ENTRIES-1:0] live_i,
    input  logic [N_ENTRIES-1:0] ins_hit_i,
    output logic [N_ENTRIES-1:0] wr_sel_o
);

    localparam int PTR_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1;
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(N_ENTRIES - 1);

    alloc_mode_e          mode;
    logic [PTR_W-1:0]     ptr_q, ptr_d;
    logic [N_ENTRIES-1:0] free_v, lowest_free, victim;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    always_comb begin
        free_v      = ~live_i;
        lowest_free = free_v & (~free_v + N_ENTRIES'(1));
        victim      = '0;
        victim[ptr_q] = 1'b1;
    end

    always_comb begin
        if (!ins_valid_i)    mode = ALLOC_NONE;
        else if (|ins_hit_i) mode = ALLOC_REFRESH;
        else if (|free_v)    mode = ALLOC_FILL;
        else                 mode = ALLOC_EVICT;
    end

    always_comb begin
        unique case (mode)
            ALLOC_NONE:    wr_sel_o = '0;
            ALLOC_REFRESH: wr_sel_o = ins_hit_i;
            ALLOC_FILL:    wr_sel_o = lowest_free;
            ALLOC_EVICT:   wr_sel_o = victim;
            default:       wr_sel_o = '0;
        endcase
    end

    always_comb begin
        if (flush_i)                  ptr_d = '0;
        else if (mode == ALLOC_EVICT) ptr_d = (ptr_q == PTR_LAST) ? '0 : ptr_q + 1'b1;
        else                          ptr_d = ptr_q;
    end

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_sel_o)); // R6

    AST_EVICT_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == ALLOC_EVICT) |-> (live_i == '1)); // R7

    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != ALLOC_EVICT && !flush_i) |=> $stable(ptr_q)); // R7

    AST_PTR_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (ptr_q == '0)); // R9

endmodule

// File: rtl/spec_ld_table.sv
module spec_ld_table
    import spec_ld_pkg::*;
#(
    parameter int N_ENTRIES = 8,
    parameter int REG_W     = 7,
    parameter int ADDR_W    = 32,
    parameter int IGN_BITS  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic              ins_valid_i,
    input  logic [REG_W-1:0]  ins_reg_i,
    input  logic [ADDR_W-1:0] ins_addr_i,
    input  logic              st_valid_i,
    input  logic [ADDR_W-1:0] st_addr_i,
    input  logic              chk_valid_i,
    input  logic [REG_W-1:0]  chk_reg_i,
    input  logic              chk_clear_i,
    output logic              chk_ok_o,
    output logic              chk_recover_o
);

    logic [N_ENTRIES-1:0] live_v, ins_hit_v, chk_hit_v, wr_sel_v;

    spec_ld_alloc #(.N_ENTRIES(N_ENTRIES)) u_alloc (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush_i     (flush_i),
        .ins_valid_i (ins_valid_i),
        .live_i      (live_v),
        .ins_hit_i   (ins_hit_v),
        .wr_sel_o    (wr_sel_v)
    );

    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_slot
        spec_ld_entry #(
            .REG_W    (REG_W),
            .ADDR_W   (ADDR_W),
            .IGN_BITS (IGN_BITS)
        ) u_entry (
            .clk         (clk),
            .rst_n       (rst_n),
            .flush_i     (flush_i),
            .load_i      (wr_sel_v[g]),
            .ins_reg_i   (ins_reg_i),
            .ins_addr_i  (ins_addr_i),
            .st_valid_i  (st_valid_i),
            .st_addr_i   (st_addr_i),
            .chk_valid_i (chk_valid_i),
            .chk_reg_i   (chk_reg_i),
            .chk_clear_i (chk_clear_i),
            .live_o      (live_v[g]),
            .ins_hit_o   (ins_hit_v[g]),
            .chk_hit_o   (chk_hit_v[g])
        );
    end

    always_comb begin
        chk_ok_o      = chk_valid_i && (|chk_hit_v);
        chk_recover_o = chk_valid_i && !(|chk_hit_v);
    end

    AST_CHECK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid_i |-> (chk_ok_o != chk_recover_o)); // R4

    AST_CHECK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_valid_i |-> (!chk_ok_o && !chk_recover_o)); // R4

    AST_ONE_PER_REG: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(chk_hit_v)); // R6

    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (live_v == '0)); // R9

    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !ins_valid_i |-> (wr_sel_v == '0)); // R10

endmodule

// File: tb/spec_ld_table_test.sv
module spec_ld_table_test;

    localparam int CLK_PERIOD = 10;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush_i = 1'b0;
    logic        ins_valid_i = 1'b0;
    logic [6:0]  ins_reg_i = '0;
    logic [31:0] ins_addr_i = '0;
    logic        st_valid_i = 1'b0;
    logic [31:0] st_addr_i = '0;
    logic        chk_valid_i = 1'b0;
    logic [6:0]  chk_reg_i = '0;
    logic        chk_clear_i = 1'b0;
    logic        chk_ok_o, chk_recover_o;

    bit          m_live [N];
    logic [6:0]  m_reg  [N];
    logic [31:0] m_addr [N];
    int          m_ptr = 0;

    int n_vec = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spec_ld_table uut (
        .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
        .ins_valid_i(ins_valid_i), .ins_reg_i(ins_reg_i), .ins_addr_i(ins_addr_i),
        .st_valid_i(st_valid_i), .st_addr_i(st_addr_i),
        .chk_valid_i(chk_valid_i), .chk_reg_i(chk_reg_i), .chk_clear_i(chk_clear_i),
        .chk_ok_o(chk_ok_o), .chk_recover_o(chk_recover_o)
    );

    function automatic bit model_present(logic [6:0] r);
        for (int i = 0; i < N; i++)
            if (m_live[i] && m_reg[i] == r) return 1'b1;
        return 1'b0;
    endfunction

    task automatic model_step();
        bit old_live [N];
        int slot;
        if (flush_i) begin
            for (int i = 0; i < N; i++) m_live[i] = 1'b0;
            m_ptr = 0;
            return;
        end
        for (int i = 0; i < N; i++) old_live[i] = m_live[i];
        for (int i = 0; i < N; i++) begin
            if (old_live[i] && st_valid_i && m_addr[i][31:3] == st_addr_i[31:3]) m_live[i] = 1'b0;
            if (old_live[i] && chk_valid_i && chk_clear_i && m_reg[i] == chk_reg_i) m_live[i] = 1'b0;
        end
        if (ins_valid_i) begin
            slot = -1;
            for (int i = 0; i < N; i++)
                if (slot < 0 && old_live[i] && m_reg[i] == ins_reg_i) slot = i;
            for (int i = 0; i < N; i++)
                if (slot < 0 && !old_live[i]) slot = i;
            if (slot < 0) begin
                slot = m_ptr;
                m_ptr = (m_ptr + 1) % N;
            end
            m_live[slot] = 1'b1;
            m_reg[slot]  = ins_reg_i;
            m_addr[slot] = ins_addr_i;
        end
    endtask

    // one clock of stimulus; outputs sampled mid-cycle, model advanced for the next edge
    task automatic cyc(input logic iv, input logic [6:0] ir, input logic [31:0] ia,
                       input logic sv, input logic [31:0] sa,
                       input logic cv, input logic [6:0] cr, input logic cc,
                       input logic fl, input bit use_exp, input bit exp_ok,
                       input string tag);
        bit m_ok, m_rec;
        @(negedge clk);
        ins_valid_i = iv; ins_reg_i = ir; ins_addr_i = ia;
        st_valid_i = sv;  st_addr_i = sa;
        chk_valid_i = cv; chk_reg_i = cr; chk_clear_i = cc;
        flush_i = fl;
        #1;
        m_ok  = cv && model_present(cr);
        m_rec = cv && !model_present(cr);
        n_vec++;
        if (chk_ok_o !== m_ok || chk_recover_o !== m_rec) begin
            n_fail++;
            $display("FAIL R4 model (%s): ok/recover actual %b/%b expected %b/%b",
                     tag, chk_ok_o, chk_recover_o, m_ok, m_rec);
        end
        if (use_exp) begin
            n_vec++;
            if (chk_ok_o !== exp_ok || chk_recover_o !== !exp_ok) begin
                n_fail++;
                $display("FAIL %s: ok/recover actual %b/%b expected %b/%b",
                         tag, chk_ok_o, chk_recover_o, exp_ok, !exp_ok);
            end
        end
        model_step();
    endtask

    task automatic ins(input logic [6:0] r, input logic [31:0] a, input string tag);
        cyc(1, r, a, 0, '0, 0, '0, 0, 0, 0, 0, tag);
    endtask

    task automatic st(input logic [31:0] a, input string tag);
        cyc(0, '0, '0, 1, a, 0, '0, 0, 0, 0, 0, tag);
    endtask

    task automatic chk(input logic [6:0] r, input logic clr, input bit exp_ok, input string tag);
        cyc(0, '0, '0, 0, '0, 1, r, clr, 0, 1, exp_ok, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            m_live[i] = 1'b0; m_reg[i] = '0; m_addr[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: empty after reset
        chk(7'd5, 0, 0, "R1 empty after reset");

        // R2 / R5: insert then check without clear, twice
        ins(7'd1, 32'h100, "R2");
        chk(7'd1, 0, 1, "R2 present after insert");
        chk(7'd1, 0, 1, "R5 kept after plain check");

        // R3: same granule kills, other granule spares
        st(32'h104, "R3");
        chk(7'd1, 0, 0, "R3 killed by low-bit alias");
        ins(7'd2, 32'h200, "R3");
        st(32'h208, "R3");
        chk(7'd2, 0, 1, "R3 next granule spares");

        // R5: clear removes
        chk(7'd2, 1, 1, "R5 clear check reports hit");
        chk(7'd2, 0, 0, "R5 gone after clear");

        // R4: same-cycle insert and store are not visible to the lookup
        cyc(1, 7'd3, 32'h300, 0, '0, 1, 7'd3, 0, 0, 1, 0, "R4 insert not yet visible");
        chk(7'd3, 0, 1, "R4 visible next cycle");
        cyc(0, '0, '0, 1, 32'h300, 1, 7'd3, 0, 0, 1, 1, "R4 store not yet visible");
        chk(7'd3, 0, 0, "R4 store kill seen next cycle");

        // R6: overwrite same register
        ins(7'd4, 32'h400, "R6");
        ins(7'd4, 32'h500, "R6");
        st(32'h400, "R6");
        chk(7'd4, 0, 1, "R6 old address replaced");
        st(32'h500, "R6");
        chk(7'd4, 0, 0, "R6 new address killed");

        // R8: insert after same-cycle store and clear
        cyc(1, 7'd6, 32'h600, 1, 32'h600, 0, '0, 0, 0, 0, 0, "R8");
        chk(7'd6, 0, 1, "R8 insert survives same-cycle store");
        cyc(1, 7'd6, 32'h640, 0, '0, 1, 7'd6, 1, 0, 1, 1, "R8 insert with clear");
        chk(7'd6, 0, 1, "R8 insert survives same-cycle clear");

        // R10: idle ports ignore their data
        cyc(0, '0, '0, 0, 32'h640, 0, '0, 0, 0, 0, 0, "R10");
        chk(7'd6, 0, 1, "R10 store with valid low ignored");
        cyc(1'b0, 7'd9, 32'h900, 0, '0, 0, '0, 0, 0, 0, 0, "R10");
        chk(7'd9, 0, 0, "R10 insert with valid low ignored");

        // R9: flush wins over insert
        ins(7'd8, 32'h800, "R9");
        cyc(1, 7'd7, 32'h700, 0, '0, 0, '0, 0, 1, 0, 0, "R9");
        chk(7'd7, 0, 0, "R9 flush beats insert");
        chk(7'd8, 0, 0, "R9 flush empties table");
        chk(7'd6, 0, 0, "R9 flush empties table");

        // R7: fill, round-robin eviction
        for (int k = 0; k < N; k++) ins(7'(10 + k), 32'h1000 + 32'(k * 64), "R7");
        ins(7'd20, 32'h2000, "R7");
        chk(7'd10, 0, 0, "R7 slot 0 evicted first");
        chk(7'd11, 0, 1, "R7 slot 1 kept");
        ins(7'd21, 32'h2040, "R7");
        chk(7'd11, 0, 0, "R7 pointer advanced to slot 1");
        cyc(0, '0, '0, 0, '0, 0, '0, 0, 1, 0, 0, "R9");
        for (int k = 0; k < N; k++) ins(7'(30 + k), 32'h3000 + 32'(k * 64), "R7");
        chk(7'd32, 1, 1, "R7 free middle slot");
        ins(7'd41, 32'h4000, "R7");
        ins(7'd42, 32'h4040, "R7");
        chk(7'd30, 0, 0, "R9 pointer back at slot 0 after flush");
        chk(7'd41, 0, 1, "R7 lowest free slot used");
        chk(7'd31, 0, 1, "R7 fill did not move pointer");

        // random traffic against the model
        for (int n = 0; n < 4000; n++) begin
            logic iv, sv, cv, cc, fl;
            logic [6:0] ir, cr;
            logic [31:0] ia, sa;
            iv = ($urandom_range(0, 99) < 45);
            sv = ($urandom_range(0, 99) < 35);
            cv = ($urandom_range(0, 99) < 60);
            cc = ($urandom_range(0, 99) < 30);
            fl = ($urandom_range(0, 99) < 2);
            ir = 7'($urandom_range(0, 11));
            cr = 7'($urandom_range(0, 11));
            ia = 32'($urandom_range(0, 5) * 8 + $urandom_range(0, 7)) + 32'h8000;
            sa = 32'($urandom_range(0, 5) * 8 + $urandom_range(0, 7)) + 32'h8000;
            cyc(iv, ir, ia, sv, sa, cv, cr, cc, fl, 0, 0, "R2 R3 R6 R7 random");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule